// File: doc/BRIEF.md
# MSI Doorbell to Shared Interrupt Frame

This block is a small memory-mapped register frame that converts message-signalled interrupt writes into pulses on shared peripheral interrupt lines. A device or bridge writes an interrupt number into a doorbell register. The frame owns one contiguous window of shared interrupt numbers, fixed by two elaboration parameters. When the written number falls inside that window, the frame fires a one-clock pulse on the matching local output line.

A doorbell whose number lies outside the window is rejected. A rejection fires a one-clock error pulse and records the offending number in a status register. Software can find out which numbers the frame serves by reading a packed type register that holds the base number and the line count. An identification register reads as zero. Access is through a simple single-cycle register bus, and read data comes back one clock after the read strobe.

The window must lie inside the shared interrupt range, 32 to 1019. Elaboration stops with an error if the parameters break this rule.

Top module: `msi_spi_frame`

## Requirements
- R1: A read of byte offset 0x008 returns the type word `(FIRST_LINE << 16) | LINE_COUNT`, with each field 10 bits wide and all other bits zero.
- R2: A read of byte offset 0xFCC (identification) always returns zero.
- R3: A write to byte offset 0x040 (doorbell) takes bits [9:0] of the write data as the interrupt number `id` and ignores bits [31:10]. If `FIRST_LINE <= id < FIRST_LINE + LINE_COUNT`, output `line_trig` bit `id - FIRST_LINE` is high for exactly the one clock after the write edge, and every other bit stays low.
- R4: A doorbell number outside the window raises no `line_trig` bit. Instead, `err_pulse` is high for exactly the one clock after the write edge. `err_pulse` is never high together with any `line_trig` bit.
- R5: Each rejected doorbell stores its 10-bit number in the reject status register. That register reads at byte offset 0x0F0, with bits [31:10] zero. It resets to zero, and accepted doorbells leave it unchanged.
- R6: A read of any offset other than 0x008, 0x0F0 and 0xFCC returns zero. `rd_data` carries the read result in the clock after the `rd_en` edge, and it is zero in any clock that does not follow a read.
- R7: Writes to 0x008, 0x0F0, 0xFCC and to unmapped offsets have no effect. They raise no `line_trig` or `err_pulse`, and the type register and the reject status register keep their values.
- R8: Doorbell writes on consecutive clocks each produce their own pulse in consecutive clocks, and no write is lost.
- R9: While reset is held and right after it is released, `line_trig`, `err_pulse` and `rd_data` are zero, and the reject status register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset within the frame |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, one clock after `rd_en` |
| line_trig | output | LINE_COUNT | One pulse per accepted doorbell, one bit per owned line |
| err_pulse | output | 1 | Pulse on a rejected doorbell |

## Verification
Every result of this frame is due exactly one clock edge after the stimulus that causes it. This holds for trigger pulses, the error pulse, the captured reject number and read data. The bench drives each write or read on a falling edge and samples the outputs on the next falling edge, half a period after the edge that registers them. It then clears the strobes, so that no stale pulse is seen. For the back-to-back case, the bench loads the next doorbell on the same falling edge where it checks the previous pulse. In this way each pulse is checked in its own clock, and a one-clock-late or stretched pulse is caught.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ID_W   = 10;

    localparam logic [ADDR_W-1:0] OFS_TYPE   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_DOOR   = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_REJECT = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFS_IDENT  = 12'hFCC;

    localparam int SHARED_LO = 32;
    localparam int SHARED_HI = 1019;

    function automatic logic [DATA_W-1:0] type_word(input int base, input int count);
        logic [DATA_W-1:0] w;
        w = '0;
        w[16 +: ID_W] = ID_W'(base);
        w[0  +: ID_W] = ID_W'(count);
        return w;
    endfunction
endpackage

// File: rtl/msi_door_check.sv
module msi_door_check
    import msi_frame_pkg::*;
#(
    parameter int FIRST_LINE = 96,
    parameter int LINE_COUNT = 64,
    localparam int IDX_W = (LINE_COUNT > 1) ? $clog2(LINE_COUNT) : 1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              door_hit,
    output logic              in_window,
    output logic [ID_W-1:0]   door_id,
    output logic [IDX_W-1:0]  local_idx
);
    localparam logic [ID_W:0] LO_BOUND = (ID_W+1)'(FIRST_LINE);
    localparam logic [ID_W:0] HI_BOUND = (ID_W+1)'(FIRST_LINE + LINE_COUNT);

    logic [ID_W:0] id_ext;
    logic [ID_W:0] offset;

    always_comb begin
        door_hit  = wr_en && (bus_addr == OFS_DOOR);
        door_id   = wr_data[ID_W-1:0];
        id_ext    = {1'b0, door_id};
        in_window = (id_ext >= LO_BOUND) && (id_ext < HI_BOUND);
        offset    = id_ext - LO_BOUND;
        local_idx = offset[IDX_W-1:0];
    end
endmodule

// File: rtl/msi_pulse_reg.sv
module msi_pulse_reg
    import msi_frame_pkg::*;
#(
    parameter int LINE_COUNT = 64,
    localparam int IDX_W = (LINE_COUNT > 1) ? $clog2(LINE_COUNT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  door_hit,
    input  logic                  in_window,
    input  logic [ID_W-1:0]       door_id,
    input  logic [IDX_W-1:0]      local_idx,
    output logic [LINE_COUNT-1:0] line_trig,
    output logic                  err_pulse,
    output logic [ID_W-1:0]       reject_id
);
    typedef struct packed {
        logic [LINE_COUNT-1:0] trig;
        logic                  err;
        logic [ID_W-1:0]       rej;
    } pulse_state_t;

    pulse_state_t st_d, st_q;
    logic [LINE_COUNT-1:0] line_sel;

    for (genvar g = 0; g < LINE_COUNT; g++) begin : g_line
        assign line_sel[g] = (local_idx == IDX_W'(g));
    end

    always_comb begin
        st_d      = st_q;
        st_d.trig = '0;
        st_d.err  = 1'b0;
        if (door_hit) begin
            if (in_window) begin
                st_d.trig = line_sel;
            end else begin
                st_d.err = 1'b1;
                st_d.rej = door_id;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_trig = st_q.trig;
    assign err_pulse = st_q.err;
    assign reject_id = st_q.rej;

    AST_TRIG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line_trig)); // R3
    AST_ERR_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (line_trig == '0)); // R4
    AST_TRIG_FROM_DOOR: assert property (@(posedge clk) disable iff (!rst_n)
        door_hit && in_window |=> $countones(line_trig) == 1); // R8
    AST_ERR_FROM_DOOR: assert property (@(posedge clk) disable iff (!rst_n)
        !door_hit |=> !err_pulse && (line_trig == '0)); // R7
    AST_REJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(door_hit && !in_window) |=> $stable(reject_id)); // R5
endmodule

// File: rtl/msi_read_port.sv
module msi_read_port
    import msi_frame_pkg::*;
#(
    parameter int FIRST_LINE = 96,
    parameter int LINE_COUNT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ID_W-1:0]   reject_id,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] TYPE_VAL = type_word(FIRST_LINE, LINE_COUNT);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d.data = '0;
        if (rd_en) begin
            unique case (bus_addr)
                OFS_TYPE:   rd_d.data = TYPE_VAL;
                OFS_REJECT: rd_d.data = {{(DATA_W-ID_W){1'b0}}, reject_id};
                OFS_IDENT:  rd_d.data = '0;
                default:    rd_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q.data;

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0)); // R6
    AST_RD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (bus_addr == OFS_TYPE) |=> (rd_data == TYPE_VAL)); // R1
endmodule

// File: rtl/msi_spi_frame.sv
module msi_spi_frame
    import msi_frame_pkg::*;
#(
    parameter int FIRST_LINE = 96,
    parameter int LINE_COUNT = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [11:0]           bus_addr,
    input  logic                  wr_en,
    input  logic [31:0]           wr_data,
    input  logic                  rd_en,
    output logic [31:0]           rd_data,
    output logic [LINE_COUNT-1:0] line_trig,
    output logic                  err_pulse
);
    localparam int IDX_W = (LINE_COUNT > 1) ? $clog2(LINE_COUNT) : 1;

    if (FIRST_LINE < SHARED_LO || LINE_COUNT < 1 ||
        FIRST_LINE + LINE_COUNT - 1 > SHARED_HI) begin : g_bad_window
        $error("msi_spi_frame: line window outside the shared interrupt range");
    end

    logic             door_hit;
    logic             in_window;
    logic [ID_W-1:0]  door_id;
    logic [IDX_W-1:0] local_idx;
    logic [ID_W-1:0]  reject_id;

    msi_door_check #(.FIRST_LINE(FIRST_LINE), .LINE_COUNT(LINE_COUNT)) u_check (
        .wr_en     (wr_en),
        .bus_addr  (bus_addr),
        .wr_data   (wr_data),
        .door_hit  (door_hit),
        .in_window (in_window),
        .door_id   (door_id),
        .local_idx (local_idx)
    );

    msi_pulse_reg #(.LINE_COUNT(LINE_COUNT)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .door_hit  (door_hit),
        .in_window (in_window),
        .door_id   (door_id),
        .local_idx (local_idx),
        .line_trig (line_trig),
        .err_pulse (err_pulse),
        .reject_id (reject_id)
    );

    msi_read_port #(.FIRST_LINE(FIRST_LINE), .LINE_COUNT(LINE_COUNT)) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .bus_addr  (bus_addr),
        .reject_id (reject_id),
        .rd_data   (rd_data)
    );
endmodule

// File: tb/msi_spi_frame_tb.sv
module msi_spi_frame_tb;
    localparam int FIRST = 96;
    localparam int COUNT = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [11:0]      bus_addr = '0;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic             rd_en = 1'b0;
    logic [31:0]      rd_data;
    logic [COUNT-1:0] line_trig;
    logic             err_pulse;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    msi_spi_frame #(.FIRST_LINE(FIRST), .LINE_COUNT(COUNT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .line_trig(line_trig), .err_pulse(err_pulse)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [COUNT-1:0] bit_of(input int idx);
        logic [COUNT-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; rd_en = 1'b1;
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                            input string req, input logic [COUNT-1:0] exp_trig,
                            input logic exp_err);
        @(negedge clk);
        bus_addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(req, 64'(line_trig), 64'(exp_trig));
        check(req, 64'(err_pulse), 64'(exp_err));
        @(negedge clk);
        check({req, " pulse width"}, 64'(line_trig), 64'd0);
        check({req, " pulse width"}, 64'(err_pulse), 64'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R9 trig", 64'(line_trig), 64'd0);
        check("R9 err", 64'(err_pulse), 64'd0);
        check("R9 rdata", 64'(rd_data), 64'd0);
        do_read(12'h0F0, d);
        check("R9 status", 64'(d), 64'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        do_read(12'h008, d);
        check("R1 type", 64'(d), 64'h0060_0040);
        do_read(12'hFCC, d);
        check("R2 ident", 64'(d), 64'd0);
        do_read(12'h100, d);
        check("R6 unmapped", 64'(d), 64'd0);
        do_read(12'h044, d);
        check("R6 unmapped near doorbell", 64'(d), 64'd0);
        @(negedge clk);
        check("R6 idle rdata", 64'(rd_data), 64'd0);
    endtask

    task automatic t_valid();
        do_write(12'h040, 32'(FIRST), "R3 first line", bit_of(0), 1'b0);
        do_write(12'h040, 32'(FIRST + COUNT - 1), "R3 last line", bit_of(COUNT - 1), 1'b0);
        do_write(12'h040, 32'hABCD_F000 | 32'(FIRST + 5), "R3 upper bits ignored", bit_of(5), 1'b0);
        do_write(12'h040, 32'(FIRST + 37), "R3 mid line", bit_of(37), 1'b0);
    endtask

    task automatic t_reject();
        logic [31:0] d;
        do_write(12'h040, 32'(FIRST - 1), "R4 below window", '0, 1'b1);
        do_read(12'h0F0, d);
        check("R5 status below", 64'(d), 64'(FIRST - 1));
        do_write(12'h040, 32'(FIRST + COUNT), "R4 above window", '0, 1'b1);
        do_read(12'h0F0, d);
        check("R5 status above", 64'(d), 64'(FIRST + COUNT));
        do_write(12'h040, 32'hFFFF_FFFF, "R4 id 1023", '0, 1'b1);
        do_read(12'h0F0, d);
        check("R5 status 1023", 64'(d), 64'h3FF);
        do_write(12'h040, 32'h0000_0414, "R4 id 20", '0, 1'b1);
        do_write(12'h040, 32'(FIRST + 1), "R5 valid keeps status", bit_of(1), 1'b0);
        do_read(12'h0F0, d);
        check("R5 status kept", 64'(d), 64'd20);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        do_write(12'h008, 32'(FIRST + 3), "R7 write type", '0, 1'b0);
        do_write(12'hFCC, 32'(FIRST + 3), "R7 write ident", '0, 1'b0);
        do_write(12'h0F0, 32'h0000_0155, "R7 write status", '0, 1'b0);
        do_write(12'h200, 32'(FIRST + 3), "R7 write unmapped", '0, 1'b0);
        do_read(12'h008, d);
        check("R7 type unchanged", 64'(d), 64'h0060_0040);
        do_read(12'h0F0, d);
        check("R7 status unchanged", 64'(d), 64'd20);
        do_read(12'hFCC, d);
        check("R7 ident still zero", 64'(d), 64'd0);
    endtask

    task automatic t_burst();
        @(negedge clk);
        bus_addr = 12'h040; wr_en = 1'b1; wr_data = 32'(FIRST + 2);
        @(negedge clk);
        check("R8 burst 1", 64'(line_trig), 64'(bit_of(2)));
        wr_data = 32'(FIRST + 9);
        @(negedge clk);
        check("R8 burst 2", 64'(line_trig), 64'(bit_of(9)));
        wr_data = 32'(FIRST + 9);
        @(negedge clk);
        check("R8 burst repeat", 64'(line_trig), 64'(bit_of(9)));
        wr_data = 32'd5;
        @(negedge clk);
        check("R8 burst reject trig", 64'(line_trig), 64'd0);
        check("R8 burst reject err", 64'(err_pulse), 64'd1);
        wr_data = 32'(FIRST + 63);
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 burst after reject", 64'(line_trig), 64'(bit_of(63)));
        check("R8 err cleared", 64'(err_pulse), 64'd0);
        @(negedge clk);
        check("R8 burst end", 64'(line_trig), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 in reset trig", 64'(line_trig), 64'd0);
        check("R9 in reset err", 64'(err_pulse), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_valid();
        t_reject();
        t_ignored();
        t_burst();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule